// File: doc/BRIEF.md
# FIFO Threshold Offset Programming Port

This block holds the two threshold offsets that a FIFO's flag logic compares against: one sets how close to empty the almost-empty flag fires, and one sets how close to full the almost-full flag fires. Both offsets are 12 bits wide by default. They share a single active-low load strobe. While the strobe is low, each write-enabled write-clock edge stores the data bus into whichever offset a write-side selector currently points at. The selector then flips, so successive loads alternate between the empty offset and the full offset.

Readback works on the read clock. With the strobe low and the read enable low, each read-clock edge puts the offset picked by a second, read-side selector onto the readback bus and flips that selector. The read-side selector moves on its own and never follows the write-side selector. Readback is blocked while the FIFO runs in first-word-fall-through mode.

While the strobe is low, the block also withholds the ordinary FIFO write and read strobes. The storage array, the flag comparators and any pin drivers sit outside this block.

Write-side state machine: states `W_AE` (next load goes to the empty offset) and `W_AF` (next load goes to the full offset). The transition `W_AE -> W_AF` or `W_AF -> W_AE` fires on a load-write edge. Every other edge holds the state.

Read-side state machine: states `R_AE` and `R_AF`. The transition `R_AE -> R_AF` or `R_AF -> R_AE` fires on a readback edge. Every other edge holds the state.

Top module: `ofs_prog_port`

## Requirements
- R1: After reset both offsets equal their default parameters (7 each), `rb_valid` is 0, `rb_data` is 0, and both selectors point at the empty offset.
- R2: With `load_n`=0 and `we_n`=0, successive `wr_clk` edges store `din` into the empty offset, then the full offset, then the empty offset again, alternating from then on.
- R3: With `load_n`=0 and `we_n`=1, a `wr_clk` edge changes neither offset and does not move the write-side selector.
- R4: Taking `load_n` high between load-writes keeps the write-side selector. The next load-write goes to the offset after the last one written.
- R5: With `load_n`=0, `re_n`=0 and `fwft_mode`=0, a `rd_clk` edge puts the selected offset on `rb_data`, drives `rb_valid` to 1 for that cycle, and flips the read-side selector, starting from the empty offset.
- R6: The read-side selector moves only on readback edges, whatever number of load-writes has occurred.
- R7: With `fwft_mode`=1, no readback happens: `rb_valid` stays 0, `rb_data` holds, and the read-side selector does not move.
- R8: `fifo_wr_go` equals `load_n & ~we_n` and `fifo_rd_go` equals `load_n & ~re_n`, so no ordinary FIFO access is issued while `load_n` is 0.
- R9: With `load_n`=0 and `re_n`=1, a `rd_clk` edge gives no readback: `rb_valid` is 0, `rb_data` holds and the read-side selector is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous active-low reset for both sides |
| fwft_mode | input | 1 | 1 = first-word-fall-through mode, which blocks readback |
| load_n | input | 1 | Active-low offset load/readback strobe |
| we_n | input | 1 | Active-low write enable |
| re_n | input | 1 | Active-low read enable |
| din | input | OFS_W | Write data bus |
| ae_offset | output | OFS_W | Almost-empty offset value |
| af_offset | output | OFS_W | Almost-full offset value |
| rb_data | output | OFS_W | Readback data |
| rb_valid | output | 1 | 1 for the cycle after a readback edge |
| fifo_wr_go | output | 1 | Ordinary FIFO write strobe |
| fifo_rd_go | output | 1 | Ordinary FIFO read strobe |

## Verification
The hardest cases to reach from the ports are the two selectors drifting apart, and a selector position that survives a period with the strobe raised. Neither selector is visible directly. The stimulus therefore leaves the write-side selector on the full offset with an odd number of load-writes, raises and lowers the strobe, and then performs readbacks. The order of values on `rb_data` then shows where each selector stood. Edges that should have no effect (write enable high, read enable high, first-word-fall-through mode) are placed between the loads and the readbacks. A selector that moved wrongly would then show up as swapped readback values.

// File: rtl/ofsprog_pkg.sv
package ofsprog_pkg;
    typedef enum logic {
        SEL_AE = 1'b0,
        SEL_AF = 1'b1
    } ofs_sel_e;
endpackage

// File: rtl/ofs_wr_ctrl.sv
module ofs_wr_ctrl
    import ofsprog_pkg::*;
#(
    parameter int OFS_W = 12,
    parameter logic [OFS_W-1:0] DEF_AE = OFS_W'(7),
    parameter logic [OFS_W-1:0] DEF_AF = OFS_W'(7)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_n,
    input  logic             we_n,
    input  logic [OFS_W-1:0] din,
    output logic [OFS_W-1:0] ae_q,
    output logic [OFS_W-1:0] af_q
);
    typedef enum logic {
        W_AE = SEL_AE,
        W_AF = SEL_AF
    } wr_state_e;

    wr_state_e state, state_nxt;
    logic      ld_wr;

    assign ld_wr = ~load_n & ~we_n;

    always_comb begin
        state_nxt = state;
        unique case (state)
            W_AE: if (ld_wr) state_nxt = W_AF;
            W_AF: if (ld_wr) state_nxt = W_AE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= W_AE;
        else        state <= state_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ae_q <= DEF_AE;
            af_q <= DEF_AF;
        end else if (ld_wr) begin
            unique case (state)
                W_AE: ae_q <= din;
                W_AF: af_q <= din;
            endcase
        end
    end

    // R3
    wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n || we_n) |=> ($stable(state) && $stable(ae_q) && $stable(af_q)));

    // R2
    wr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_n && !we_n) |=> (state != $past(state)));

    // R2
    wr_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_n && !we_n) |=> ((ae_q == $past(din)) || (af_q == $past(din))));
endmodule

// File: rtl/ofs_rd_ctrl.sv
module ofs_rd_ctrl
    import ofsprog_pkg::*;
#(
    parameter int OFS_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_n,
    input  logic             re_n,
    input  logic             we_n,
    input  logic             fwft,
    input  logic [OFS_W-1:0] ae_q,
    input  logic [OFS_W-1:0] af_q,
    output logic [OFS_W-1:0] rb_data,
    output logic             rb_valid
);
    typedef enum logic {
        R_AE = SEL_AE,
        R_AF = SEL_AF
    } rd_state_e;

    rd_state_e state, state_nxt;
    logic      rb_go;

    // write side has priority: a concurrent load-write suppresses readback
    assign rb_go = ~load_n & ~re_n & ~fwft & we_n;

    always_comb begin
        state_nxt = state;
        unique case (state)
            R_AE: if (rb_go) state_nxt = R_AF;
            R_AF: if (rb_go) state_nxt = R_AE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= R_AE;
        else        state <= state_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rb_data  <= '0;
            rb_valid <= 1'b0;
        end else begin
            rb_valid <= rb_go;
            if (rb_go) begin
                unique case (state)
                    R_AE: rb_data <= ae_q;
                    R_AF: rb_data <= af_q;
                endcase
            end
        end
    end

    // R7
    rd_fwft_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fwft |=> (!rb_valid && $stable(rb_data) && $stable(state)));

    // R9
    rd_idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n || re_n) |=> ($stable(state) && $stable(rb_data)));

    // R5
    rd_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rb_valid |-> (state != $past(state)));
endmodule

// File: rtl/ofs_prog_port.sv
module ofs_prog_port
    import ofsprog_pkg::*;
#(
    parameter int OFS_W = 12,
    parameter logic [OFS_W-1:0] DEF_AE = OFS_W'(7),
    parameter logic [OFS_W-1:0] DEF_AF = OFS_W'(7)
) (
    input  logic             wr_clk,
    input  logic             rd_clk,
    input  logic             rst_n,
    input  logic             fwft_mode,
    input  logic             load_n,
    input  logic             we_n,
    input  logic             re_n,
    input  logic [OFS_W-1:0] din,
    output logic [OFS_W-1:0] ae_offset,
    output logic [OFS_W-1:0] af_offset,
    output logic [OFS_W-1:0] rb_data,
    output logic             rb_valid,
    output logic             fifo_wr_go,
    output logic             fifo_rd_go
);
    ofs_wr_ctrl #(
        .OFS_W  (OFS_W),
        .DEF_AE (DEF_AE),
        .DEF_AF (DEF_AF)
    ) wr_ctrl_i (
        .clk    (wr_clk),
        .rst_n  (rst_n),
        .load_n (load_n),
        .we_n   (we_n),
        .din    (din),
        .ae_q   (ae_offset),
        .af_q   (af_offset)
    );

    // offsets are quasi-static by the time the read side samples them
    ofs_rd_ctrl #(
        .OFS_W (OFS_W)
    ) rd_ctrl_i (
        .clk      (rd_clk),
        .rst_n    (rst_n),
        .load_n   (load_n),
        .re_n     (re_n),
        .we_n     (we_n),
        .fwft     (fwft_mode),
        .ae_q     (ae_offset),
        .af_q     (af_offset),
        .rb_data  (rb_data),
        .rb_valid (rb_valid)
    );

    assign fifo_wr_go = load_n & ~we_n;
    assign fifo_rd_go = load_n & ~re_n;

    // R8
    always_comb begin
        if (!load_n) begin
            no_fifo_access_chk: assert (!fifo_wr_go && !fifo_rd_go);
        end
    end

    // R5
    rb_needs_load_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
        rb_valid |-> $past(!load_n && !re_n));
endmodule

// File: tb/ofs_prog_port_tb_top.sv
module ofs_prog_port_tb_top;
    localparam int W = 12;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic         rst_n, fwft_mode, load_n, we_n, re_n;
    logic [W-1:0] din, ae_offset, af_offset, rb_data;
    logic         rb_valid, fifo_wr_go, fifo_rd_go;

    ofs_prog_port #(.OFS_W(W)) dut_i (
        .wr_clk     (clk),
        .rd_clk     (clk),
        .rst_n      (rst_n),
        .fwft_mode  (fwft_mode),
        .load_n     (load_n),
        .we_n       (we_n),
        .re_n       (re_n),
        .din        (din),
        .ae_offset  (ae_offset),
        .af_offset  (af_offset),
        .rb_data    (rb_data),
        .rb_valid   (rb_valid),
        .fifo_wr_go (fifo_wr_go),
        .fifo_rd_go (fifo_rd_go)
    );

    int vectors = 0;
    int errors  = 0;

    // behavioural reference
    int m_ae = 7, m_af = 7, m_wp = 0, m_rp = 0, m_rb = 0, m_rbv = 0;

    task automatic chk(string req, string what, logic [15:0] act, logic [15:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic compare_all(string req);
        chk(req, "ae_offset", 16'(ae_offset), 16'(m_ae));
        chk(req, "af_offset", 16'(af_offset), 16'(m_af));
        chk(req, "rb_valid",  16'(rb_valid),  16'(m_rbv));
        chk(req, "rb_data",   16'(rb_data),   16'(m_rb));
    endtask

    task automatic step(string req, bit ld, bit we, bit re, bit fw, int d);
        load_n = ld; we_n = we; re_n = re; fwft_mode = fw; din = W'(d);
        #1;
        // R8: ordinary strobes follow the enables only with load high
        chk("R8", "fifo_wr_go", 16'(fifo_wr_go), 16'(ld & ~we));
        chk("R8", "fifo_rd_go", 16'(fifo_rd_go), 16'(ld & ~re));
        @(posedge clk);
        begin
            int old_ae = m_ae, old_af = m_af;
            if (!ld && !we) begin
                if (m_wp == 0) m_ae = d & 12'hFFF; else m_af = d & 12'hFFF;
                m_wp ^= 1;
            end
            if (!ld && !re && !fw && we) begin
                m_rb  = (m_rp == 0) ? old_ae : old_af;
                m_rbv = 1;
                m_rp ^= 1;
            end else begin
                m_rbv = 0;
            end
        end
        @(negedge clk);
        compare_all(req);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
        $finish;
    end

    initial begin
        rst_n = 1'b0; fwft_mode = 1'b0; load_n = 1'b1; we_n = 1'b1; re_n = 1'b1; din = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: defaults after reset
        compare_all("R1");

        // R1 / R5: first readback after reset selects the empty offset
        step("R1", 0, 1, 0, 0, 0);
        step("R5", 0, 1, 1, 0, 0);
        // R5: second readback gives the full offset, then empty again
        step("R5", 0, 1, 0, 0, 0);
        step("R5", 0, 1, 0, 0, 0);   // rp now on full

        // R2: three load-writes alternate empty, full, empty
        step("R2", 0, 0, 1, 0, 'h0A5);
        step("R2", 0, 0, 1, 0, 'h123);
        step("R2", 0, 0, 1, 0, 'h042);

        // R3: write enable high leaves offsets and selector alone
        step("R3", 0, 1, 1, 0, 'hFFF);
        step("R3", 0, 1, 1, 0, 'h555);

        // R4: raise load, then resume at the full offset
        step("R4", 1, 1, 1, 0, 0);
        step("R4", 0, 0, 1, 0, 'h300);
        step("R4", 1, 1, 1, 0, 0);
        step("R4", 0, 0, 1, 0, 'h111);

        // R6: read selector was left on full; writes did not move it
        step("R6", 0, 1, 0, 0, 0);
        step("R6", 0, 1, 0, 0, 0);

        // R7: first-word-fall-through blocks readback
        step("R7", 0, 1, 0, 1, 0);
        step("R7", 0, 1, 0, 1, 0);
        step("R7", 0, 1, 0, 0, 0);   // should read full offset

        // R9: read enable high gives no readback
        step("R9", 0, 1, 1, 0, 0);
        step("R9", 0, 1, 0, 0, 0);   // should read empty offset

        // R8: ordinary traffic with load high
        step("R8", 1, 0, 1, 0, 'h7AA);
        step("R8", 1, 1, 0, 0, 0);
        step("R8", 1, 0, 0, 0, 'h001);
        step("R8", 0, 0, 1, 0, 'hABC);

        // R2: odd pattern values across all bits
        step("R2", 0, 0, 1, 0, 'hFFF);
        step("R2", 0, 0, 1, 0, 'h000);
        step("R5", 0, 1, 0, 0, 0);
        step("R5", 0, 1, 0, 0, 0);

        summary();
        $finish;
    end
endmodule